// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a two-wire serial slave that accepts only block-write transactions and loads a bank of configuration bytes. It runs on a system clock much faster than the serial clock. It synchronizes the SCL and SDA lines and finds START and STOP conditions and clock edges. It then frames the incoming bits into bytes and answers each byte with an acknowledge or a negative acknowledge. To acknowledge, it pulls SDA low through an open-drain enable output.

A transaction is made of several bytes, in this order:
- an address byte, which must match a fixed 8-bit pattern that includes the write direction bit;
- a command byte, which must be zero;
- a count byte, which must be between 1 and 32 and gives the number of data bytes that follow;
- the data bytes.

There is no register index. Data always lands in register byte 0 first and advances by one per byte. The host may end the transfer with STOP after any complete byte, and bytes already taken stay written.

The register bank is presented as one flat parallel output, with a one-cycle strobe per byte written, so that downstream logic can react to each update.

Top module: `smb_blkwr_slave`

## Requirements
- R1: After reset every configuration byte reads 0x00, no write strobe is active and the SDA pull-down enable is low.
- R2: An address byte equal to 0xD2 (seven address bits 1101001 followed by write bit 0) is acknowledged. Any other value, including 0xD3 with the read bit set, is not acknowledged, and the slave then ignores the bus until the next START.
- R3: The command byte is acknowledged only when it equals 0x00. Any other command is not acknowledged, and no register changes.
- R4: The count byte is acknowledged only for values 1 to 32. A count of 0 or above 32 is not acknowledged, and no register changes.
- R5: Data byte k of a transfer (k counted from 0) is written to register byte k, which appears on cfg_o[8k+7:8k]. Each byte written raises exactly one bit, wr_stb_o[k], for exactly one clock cycle, and the strobes come in ascending order.
- R6: A STOP after any complete data byte keeps the bytes already written and leaves every other register byte unchanged.
- R7: A data byte past the declared count is not acknowledged and not written.
- R8: The acknowledge pull-down starts only on the SCL falling edge that ends the eighth bit and is released on the next SCL falling edge. SDA is never pulled low while the host is shifting data bits.
- R9: A repeated START in the middle of a transfer restarts framing at the address byte, and the data index starts again at register byte 0.
- R10: Bytes clocked on the bus without a preceding START are not acknowledged and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain acknowledge) |
| cfg_o | output | 8*NREG | Register bank; byte k sits on bits 8k+7:8k |
| wr_stb_o | output | NREG | One-cycle strobe for each register byte written |

## Verification
The bench covers three groups of corner cases.

- **Transaction header.** It tries each way the header can be rejected: wrong address, read bit set, nonzero command, count of 0 and count of 33. A design that checks only part of the header would acknowledge one of these and write registers it must leave alone.
- **End of a transfer.** It stops early after three of eight data bytes and overruns a count of two with four bytes. It also fills all 32 registers. An off-by-one in the index or the count compare would show up as a missing or extra strobe, or as a byte written at the wrong position.
- **Bus events.** It sends a repeated START partway through a transfer and bytes with no START before them. A design that failed to reset its index on a restart would write the second transfer's data at byte 1. A design that did not stay idle after a NACK would acknowledge traffic it should ignore.

// File: rtl/smb_blkwr_pkg.sv
package smb_blkwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BITS,
        ST_ACKWAIT,
        ST_ACK
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } phase_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t s_d, s_q;
    logic  scl_lvl;

    assign scl_lvl = s_q.scl_sh[STAGES-1];
    assign sda_lvl = s_q.sda_sh[STAGES-1];

    always_comb begin
        s_d        = s_q;
        s_d.scl_sh = {s_q.scl_sh[STAGES-2:0], scl_i};
        s_d.sda_sh = {s_q.sda_sh[STAGES-2:0], sda_i};
        s_d.scl_p  = scl_lvl;
        s_d.sda_p  = sda_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_rise  = !s_q.scl_p && scl_lvl;
    assign scl_fall  = s_q.scl_p && !scl_lvl;
    assign start_det = s_q.scl_p && scl_lvl && s_q.sda_p && !sda_lvl;
    assign stop_det  = s_q.scl_p && scl_lvl && !s_q.sda_p && sda_lvl;

endmodule

// File: rtl/smb_frame_ctl.sv
module smb_frame_ctl
    import smb_blkwr_pkg::*;
#(
    parameter int         NREG      = 32,
    parameter int         MAX_CNT   = 32,
    parameter logic [7:0] ADDR_BYTE = 8'hD2,
    parameter logic [7:0] CMD_CODE  = 8'h00,
    localparam int        AW        = $clog2(NREG),
    localparam int        IW        = $clog2(NREG) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [7:0]    wr_data
);
    typedef struct packed {
        bus_st_e       st;
        phase_e        ph;
        logic [2:0]    bitn;
        logic [7:0]    shreg;
        logic          ackp;
        logic          dbyte;
        logic [7:0]    cnt;
        logic [IW-1:0] idx;
        logic [AW-1:0] wa;
        logic          oe;
        logic          we;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [7:0] byte_in;

    assign byte_in = {c_q.shreg[6:0], sda_lvl};

    always_comb begin
        c_d    = c_q;
        c_d.we = 1'b0;
        if (stop_det) begin
            c_d.st = ST_IDLE;
            c_d.oe = 1'b0;
        end else if (start_det) begin
            c_d.st   = ST_BITS;
            c_d.ph   = PH_ADDR;
            c_d.bitn = '0;
            c_d.idx  = '0;
            c_d.oe   = 1'b0;
        end else begin
            unique case (c_q.st)
                ST_IDLE: ;
                ST_BITS: begin
                    if (scl_rise) begin
                        c_d.shreg = byte_in;
                        c_d.bitn  = c_q.bitn + 3'd1;
                        if (c_q.bitn == 3'd7) begin
                            c_d.st    = ST_ACKWAIT;
                            c_d.dbyte = 1'b0;
                            unique case (c_q.ph)
                                PH_ADDR: begin
                                    c_d.ackp = (byte_in == ADDR_BYTE);
                                    c_d.ph   = PH_CMD;
                                end
                                PH_CMD: begin
                                    c_d.ackp = (byte_in == CMD_CODE);
                                    c_d.ph   = PH_CNT;
                                end
                                PH_CNT: begin
                                    c_d.ackp = (byte_in != 8'd0) &&
                                               (int'(byte_in) <= MAX_CNT);
                                    c_d.cnt  = byte_in;
                                    c_d.ph   = PH_DATA;
                                end
                                PH_DATA: begin
                                    c_d.ackp  = (int'(c_q.idx) < int'(c_q.cnt)) &&
                                                (int'(c_q.idx) < NREG);
                                    c_d.dbyte = 1'b1;
                                end
                                default: c_d.ackp = 1'b0;
                            endcase
                        end
                    end
                end
                ST_ACKWAIT: begin
                    if (scl_fall) begin
                        c_d.st = ST_ACK;
                        c_d.oe = c_q.ackp;
                        if (c_q.ackp && c_q.dbyte) begin
                            c_d.we  = 1'b1;
                            c_d.wa  = c_q.idx[AW-1:0];
                            c_d.idx = c_q.idx + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        c_d.oe   = 1'b0;
                        c_d.bitn = '0;
                        c_d.st   = c_q.ackp ? ST_BITS : ST_IDLE;
                    end
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
            c_q.ph <= PH_ADDR;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe  = c_q.oe;
    assign wr_en   = c_q.we;
    assign wr_idx  = c_q.wa;
    assign wr_data = c_q.shreg;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int  NREG = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [7:0]        wr_data,
    output logic [8*NREG-1:0] cfg,
    output logic [NREG-1:0]   wr_stb
);
    logic [7:0]      regs_d [NREG];
    logic [7:0]      regs_q [NREG];
    logic [NREG-1:0] stb_d, stb_q;

    always_comb begin
        regs_d = regs_q;
        stb_d  = '0;
        if (wr_en) begin
            regs_d[wr_idx] = wr_data;
            stb_d[wr_idx]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
            stb_q <= '0;
        end else begin
            regs_q <= regs_d;
            stb_q  <= stb_d;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign cfg[8*g +: 8] = regs_q[g];
    end

    assign wr_stb = stb_q;

endmodule

// File: rtl/smb_blkwr_slave.sv
module smb_blkwr_slave #(
    parameter int         NREG      = 32,
    parameter int         MAX_CNT   = 32,
    parameter int         STAGES    = 2,
    parameter logic [7:0] ADDR_BYTE = 8'hD2,
    parameter logic [7:0] CMD_CODE  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [8*NREG-1:0] cfg_o,
    output logic [NREG-1:0]   wr_stb_o
);
    localparam int AW = $clog2(NREG);

    logic          sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [AW-1:0] wr_idx;
    logic [7:0]    wr_data;

    smb_line_sync #(.STAGES(STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_frame_ctl #(
        .NREG      (NREG),
        .MAX_CNT   (MAX_CNT),
        .ADDR_BYTE (ADDR_BYTE),
        .CMD_CODE  (CMD_CODE)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    smb_reg_bank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cfg     (cfg_o),
        .wr_stb  (wr_stb_o)
    );

endmodule

// File: rtl/smb_blkwr_chk.sv
module smb_blkwr_chk #(
    parameter int NREG = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sda_oe,
    input logic            scl_fall,
    input logic            start_det,
    input logic            stop_det,
    input logic [NREG-1:0] wr_stb
);
    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |=> (wr_stb == '0));

    // R7
    strobe_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |-> sda_oe);

    // R8
    ack_drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R8
    ack_release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> ($past(scl_fall) || $past(stop_det) || $past(start_det)));

endmodule

bind smb_blkwr_slave smb_blkwr_chk #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe_o),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_stb    (wr_stb_o)
);

// File: tb/tb_smb_blkwr_slave.sv
`timescale 1ns/1ps
module tb_smb_blkwr_slave;
    localparam int NREG = 32;
    localparam int H    = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic [8*NREG-1:0] cfg;
    logic [NREG-1:0] stb;
    wire  sda_line = sda_h & ~sda_oe;

    always #10 clk = ~clk;

    smb_blkwr_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .cfg_o(cfg), .wr_stb_o(stb)
    );

    int n_run = 0, n_fail = 0;
    int stb_cnt = 0, stb_next = 0, stb_bad = 0;
    int oe_bad = 0;
    logic [7:0] mirror [NREG];
    bit done = 0;

    // {addr, cmd, count, bytes sent}
    localparam logic [31:0] VEC [0:9] = '{
        32'hD2_00_04_04, 32'hD2_00_01_01, 32'hD2_00_08_03, 32'hD3_00_02_02,
        32'hA2_00_02_02, 32'hD2_05_02_02, 32'hD2_00_00_01, 32'hD2_00_21_02,
        32'hD2_00_20_20, 32'hD2_00_02_04
    };

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                if (stb[i]) begin
                    stb_cnt++;
                    if (i != stb_next) stb_bad++;
                    stb_next = i + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; hw(H); scl = 1'b1; hw(H);
        sda_h = 1'b0; hw(H); scl = 1'b0; hw(H);
        stb_next = 0;
    endtask

    task automatic bus_stop();
        scl = 1'b0; sda_h = 1'b0; hw(H); scl = 1'b1; hw(H); sda_h = 1'b1; hw(H);
    endtask

    task automatic bit_out(input logic b, input bit is_data, output logic seen);
        sda_h = b; hw(H/2); scl = 1'b1; hw(H/2);
        seen = sda_line;
        if (is_data && sda_oe) oe_bad++;
        hw(H/2); scl = 1'b0; hw(H/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i], 1'b1, s);
        bit_out(1'b1, 1'b0, s);
        ack = !s;
        hw(H/2);
        if (sda_oe) oe_bad++;
    endtask

    function automatic logic [7:0] dpat(input int v, input int k);
        return 8'((v * 16 + k * 3 + 17) & 8'hFF);
    endfunction

    task automatic check_bank(input string req);
        int bad = -1;
        for (int k = 0; k < NREG; k++)
            if (cfg[8*k +: 8] !== mirror[k] && bad < 0) bad = k;
        chk(bad < 0, req, (bad < 0) ? 0 : int'(cfg[8*bad +: 8]),
            (bad < 0) ? 0 : int'(mirror[bad]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        for (int k = 0; k < NREG; k++) mirror[k] = 8'h00;
        hw(5);
        // R1 reset state
        chk(cfg == '0, "R1 cfg", int'(cfg[31:0]), 0);
        chk(sda_oe == 1'b0 && stb == '0, "R1 oe/strobe", int'(sda_oe), 0);
        rst_n = 1'b1;
        hw(10);

        for (int v = 0; v < 10; v++) begin
            logic [7:0] a, c, n, ns;
            bit oka, okc, okn;
            int exp_w;
            {a, c, n, ns} = VEC[v];
            oka = (a == 8'hD2);
            okc = (c == 8'h00);
            okn = (n != 0) && (n <= 32);
            exp_w = 0;
            stb_cnt = 0;
            bus_start();
            send_byte(a, ack);
            chk(ack == oka, "R2 address ack", int'(ack), int'(oka));
            if (ack) begin
                send_byte(c, ack);
                chk(ack == okc, "R3 command ack", int'(ack), int'(okc));
            end
            if (ack) begin
                send_byte(n, ack);
                chk(ack == okn, "R4 count ack", int'(ack), int'(okn));
            end
            if (ack) begin
                for (int k = 0; k < int'(ns); k++) begin
                    bit e;
                    e = (k < int'(n)) && (k < NREG);
                    send_byte(dpat(v, k), ack);
                    chk(ack == e, "R7 data ack", int'(ack), int'(e));
                    if (e) begin
                        mirror[k] = dpat(v, k);
                        exp_w++;
                    end
                    if (!ack) break;
                end
            end
            bus_stop();
            hw(H);
            check_bank("R5 R6 bank contents");
            chk(stb_cnt == exp_w, "R5 R7 strobe count", stb_cnt, exp_w);
        end
        chk(stb_bad == 0, "R5 strobe order", stb_bad, 0);

        // R10: bytes with no START, also after a NACKed address
        stb_cnt = 0;
        send_byte(8'hD2, ack);
        chk(!ack, "R10 no start ack", int'(ack), 0);
        bus_start();
        send_byte(8'hC2, ack);
        send_byte(8'hD2, ack);
        chk(!ack, "R2 idle after nack", int'(ack), 0);
        send_byte(8'h00, ack);
        send_byte(8'h01, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        hw(H);
        check_bank("R10 bank unchanged");
        chk(stb_cnt == 0, "R10 no strobes", stb_cnt, 0);

        // R9: repeated START restarts at byte 0
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h03, ack);
        send_byte(8'hAA, ack);
        mirror[0] = 8'hAA;
        bus_start();
        send_byte(8'hD2, ack);
        chk(ack, "R9 restart address ack", int'(ack), 1);
        send_byte(8'h00, ack); send_byte(8'h01, ack);
        send_byte(8'h55, ack);
        mirror[0] = 8'h55;
        bus_stop();
        hw(H);
        check_bank("R9 index restart");

        // R8: never driven during data bits, released after each ack slot
        chk(oe_bad == 0, "R8 sda drive window", oe_bad, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule